// File: doc/BRIEF.md
# Banked Memory Map Controller

This block sits between a 16-bit processor address bus and the memories of a small control system. It turns the address, memory-request, I/O-request, read and write strobes into one-hot chip selects for a read-only program store, a shared read/write area, six 2 KB supervisor areas and a 4 KB upper window. The upper window is split into a program RAM, a scratch RAM and a general RAM, and it is switched among five physical banks. Two small registers are loaded through I/O write cycles. One holds the bank number for the upper window. The other holds the program-store page.

Two areas are guarded by a lock: the lowest supervisor area and the program RAM in the window. A memory read of the magic address 0x1FFF opens the lock for exactly one access. Once that access to a guarded area has ended, the lock closes again by itself. While the lock is closed, an access to a guarded area has its strobe withheld, and a read is told to return all-ones. Such an access also sets a violation flag that stays set until reset.

All pins are plain control and status signals. The block has no stream interface and applies no back-pressure. Data-bus steering and the memories themselves are outside the block.

Top module: `bank_map_ctrl`

## Requirements
- R1: After reset the bank register holds 0, the page register holds 1 (`rom_page` = 1), the guarded areas are locked and `viol` is 0.
- R2: With `mreq_n` low, addresses 0x0000 to 0x9FFF assert only `rom_cs`. A write there keeps `mem_we_n` high and raises `wr_blocked`.
- R3: With `mreq_n` low, addresses 0xA000 to 0xBFFF assert only `shared_cs`.
- R4: With `mreq_n` low, addresses 0xC000 to 0xEFFF assert exactly one bit of `sup_cs`: bit i covers 0xC000 + i*0x800 up to 0xC7FF + i*0x800. The bit 0 area is guarded.
- R5: With `mreq_n` low, 0xF000 to 0xF7FF assert `prog_cs` (guarded), 0xF800 to 0xF8FF assert `scratch_cs`, and 0xF900 to 0xFFFF assert `gen_cs`. For any of these, `ext_addr` equals bank*0x1000 + addr[11:0]. Otherwise `ext_addr` is 0.
- R6: An I/O write (`iorq_n` and `wr_n` low, `mreq_n` high) to port 0xDC with a value from 0 to 4 loads the bank register. A value above 4 leaves the register unchanged.
- R7: An I/O write to port 0xDD with a value of 1, 2 or 3 loads the page register. Any other value leaves it unchanged.
- R8: A memory read of 0x1FFF unlocks the guarded areas once its strobe is released. A write to 0x1FFF does not unlock them.
- R9: An access to a guarded area made while unlocked is let through. The areas lock again after that access ends.
- R10: A write to a guarded area while locked keeps `mem_we_n` high and raises `wr_blocked`. A read there while locked keeps `mem_oe_n` high and raises `ff_fill`. Either access sets `viol`, which stays set until reset.
- R11: While `mreq_n` is high, no chip select is asserted, and `mem_we_n` and `mem_oe_n` stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Processor write data (used for register loads) |
| rom_cs | output | 1 | Program store select |
| shared_cs | output | 1 | Shared RAM select |
| sup_cs | output | 6 | Supervisor area selects, one-hot |
| prog_cs | output | 1 | Window program RAM select |
| scratch_cs | output | 1 | Window scratch RAM select |
| gen_cs | output | 1 | Window general RAM select |
| ext_addr | output | 15 | Physical window address, bank in bits 14:12 |
| rom_page | output | 2 | Current program-store page |
| mem_we_n | output | 1 | Gated memory write strobe, active low |
| mem_oe_n | output | 1 | Gated memory read strobe, active low |
| ff_fill | output | 1 | Blocked read: the data path must return 0xFF |
| wr_blocked | output | 1 | The current write is suppressed |
| viol | output | 1 | Sticky lock-violation flag |

## Verification
The selects, `ext_addr`, the gated strobes, `ff_fill` and `wr_blocked` are combinational and are due in the cycle the bus is driven. The bench drives each bus cycle at a falling edge and checks these outputs 1 ns later. The bank and page registers load at the rising edge inside a held I/O write, and `viol` is set at the rising edge inside the access that breaks the lock, so these are checked 1 ns after the following falling edge. A change of lock state takes effect at the rising edge after the strobe is released. For that reason each access in the bench is followed by one idle half-cycle before the next bus cycle, and the reference model updates its lock state at that point.

// File: rtl/bmm_pkg.sv
`timescale 1ns/1ps
package bmm_pkg;
  typedef enum logic [2:0] {
    RG_NONE    = 3'd0,
    RG_ROM     = 3'd1,
    RG_SHARED  = 3'd2,
    RG_SUP     = 3'd3,
    RG_PROG    = 3'd4,
    RG_SCRATCH = 3'd5,
    RG_GEN     = 3'd6
  } region_e;
endpackage

// File: rtl/bmm_decode.sv
`timescale 1ns/1ps
module bmm_decode
  import bmm_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                SUP_N       = 6,
  parameter int                SUP_SHIFT   = 11,
  parameter int                LOCKED_SUP  = 0,
  parameter logic [ADDR_W-1:0] SHARED_BASE = 'hA000,
  parameter logic [ADDR_W-1:0] SUP_BASE    = 'hC000,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 'hF000,
  parameter logic [ADDR_W-1:0] SCR_BASE    = 'hF800,
  parameter logic [ADDR_W-1:0] GEN_BASE    = 'hF900
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  output region_e           region,
  output logic [SUP_N-1:0]  sup_cs,
  output logic              lock_hit
);
  localparam int SUP_IW = (SUP_N > 1) ? $clog2(SUP_N) : 1;

  logic [SUP_IW-1:0] sup_idx;
  assign sup_idx = SUP_IW'((addr - SUP_BASE) >> SUP_SHIFT);

  always_comb begin
    region = RG_NONE;
    if (!mreq_n) begin
      if (addr < SHARED_BASE)   region = RG_ROM;
      else if (addr < SUP_BASE) region = RG_SHARED;
      else if (addr < WIN_BASE) region = RG_SUP;
      else if (addr < SCR_BASE) region = RG_PROG;
      else if (addr < GEN_BASE) region = RG_SCRATCH;
      else                      region = RG_GEN;
    end
  end

  for (genvar i = 0; i < SUP_N; i++) begin : g_sup
    assign sup_cs[i] = (region == RG_SUP) && (sup_idx == SUP_IW'(i));
  end

  assign lock_hit = sup_cs[LOCKED_SUP] || (region == RG_PROG);

  // R4: at most one supervisor area decoded at a time
  always_comb begin
    a_r4_sup_onehot: assert ($onehot0(sup_cs));
  end
endmodule

// File: rtl/bmm_ioregs.sv
`timescale 1ns/1ps
module bmm_ioregs #(
  parameter int         DATA_W    = 8,
  parameter int         NUM_BANKS = 5,
  parameter int         BANK_W    = 3,
  parameter int         PAGE_W    = 2,
  parameter int         PAGE_MIN  = 1,
  parameter int         PAGE_MAX  = 3,
  parameter logic [7:0] BANK_PORT = 8'hDC,
  parameter logic [7:0] PAGE_PORT = 8'hDD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [7:0]        port,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] bank,
  output logic [PAGE_W-1:0] page
);
  logic bank_ok, page_ok;
  assign bank_ok = 32'(wdata) < NUM_BANKS;
  assign page_ok = (32'(wdata) >= PAGE_MIN) && (32'(wdata) <= PAGE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0;
      page <= PAGE_W'(PAGE_MIN);
    end else if (io_wr) begin
      if (port == BANK_PORT && bank_ok) bank <= BANK_W'(wdata);
      if (port == PAGE_PORT && page_ok) page <= PAGE_W'(wdata);
    end
  end

  a_r6_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bank) < NUM_BANKS);
  a_r6_bad_bank_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && port == BANK_PORT && 32'(wdata) >= NUM_BANKS) |=> $stable(bank));
  a_r7_page_range: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(page) >= PAGE_MIN) && (32'(page) <= PAGE_MAX));
endmodule

// File: rtl/bmm_lock.sv
`timescale 1ns/1ps
module bmm_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic is_read,
  input  logic magic_hit,
  input  logic lock_hit,
  output logic locked,
  output logic viol
);
  logic active_q, st_lock, st_magic;
  logic start_evt, end_evt;

  assign start_evt = active && !active_q;
  assign end_evt   = !active && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      st_lock  <= 1'b0;
      st_magic <= 1'b0;
      locked   <= 1'b1;
      viol     <= 1'b0;
    end else begin
      active_q <= active;
      if (start_evt) begin
        st_lock  <= lock_hit && !locked;
        st_magic <= magic_hit && is_read;
        if (lock_hit && locked) viol <= 1'b1;
      end else if (end_evt) begin
        if (st_lock)       locked <= 1'b1;
        else if (st_magic) locked <= 1'b0;
        st_lock  <= 1'b0;
        st_magic <= 1'b0;
      end
    end
  end

  a_r10_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol);
  a_r9_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && st_lock) |=> locked);
  a_r8_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && st_magic && !st_lock) |=> !locked);
endmodule

// File: rtl/bank_map_ctrl.sv
`timescale 1ns/1ps
module bank_map_ctrl
  import bmm_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter int          NUM_BANKS  = 5,
  parameter int          WIN_W      = 12,
  parameter int          SUP_N      = 6,
  parameter int          PAGE_W     = 2,
  parameter logic [15:0] MAGIC_ADDR = 16'h1FFF,
  localparam int         BANK_W     = $clog2(NUM_BANKS),
  localparam int         EXT_W      = BANK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              rom_cs,
  output logic              shared_cs,
  output logic [SUP_N-1:0]  sup_cs,
  output logic              prog_cs,
  output logic              scratch_cs,
  output logic              gen_cs,
  output logic [EXT_W-1:0]  ext_addr,
  output logic [PAGE_W-1:0] rom_page,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              ff_fill,
  output logic              wr_blocked,
  output logic              viol
);
  region_e           region;
  logic              lock_hit, locked;
  logic              mem_rd, mem_wr, mem_act, io_wr;
  logic              blk_rd, blk_wr, in_win;
  logic [BANK_W-1:0] bank;

  assign mem_rd  = !mreq_n && !rd_n;
  assign mem_wr  = !mreq_n && !wr_n;
  assign mem_act = mem_rd || mem_wr;
  assign io_wr   = !iorq_n && mreq_n && !wr_n;

  bmm_decode #(.ADDR_W(ADDR_W), .SUP_N(SUP_N)) u_dec (
    .addr    (addr),
    .mreq_n  (mreq_n),
    .region  (region),
    .sup_cs  (sup_cs),
    .lock_hit(lock_hit)
  );

  bmm_ioregs #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
               .PAGE_W(PAGE_W)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .io_wr(io_wr),
    .port (addr[7:0]),
    .wdata(wdata),
    .bank (bank),
    .page (rom_page)
  );

  bmm_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (mem_act),
    .is_read  (!rd_n),
    .magic_hit(addr == ADDR_W'(MAGIC_ADDR)),
    .lock_hit (lock_hit),
    .locked   (locked),
    .viol     (viol)
  );

  assign rom_cs     = (region == RG_ROM);
  assign shared_cs  = (region == RG_SHARED);
  assign prog_cs    = (region == RG_PROG);
  assign scratch_cs = (region == RG_SCRATCH);
  assign gen_cs     = (region == RG_GEN);

  assign in_win   = prog_cs || scratch_cs || gen_cs;
  assign ext_addr = in_win ? {bank, addr[WIN_W-1:0]} : '0;

  assign blk_wr     = mem_wr && (rom_cs || (lock_hit && locked));
  assign blk_rd     = mem_rd && lock_hit && locked;
  assign mem_we_n   = !mem_wr || blk_wr;
  assign mem_oe_n   = !mem_rd || blk_rd;
  assign ff_fill    = blk_rd;
  assign wr_blocked = blk_wr;

  a_r11_io_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> !(rom_cs || shared_cs || (|sup_cs) || in_win) && mem_we_n && mem_oe_n);
  a_r10_locked_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && lock_hit && mem_wr) |-> mem_we_n && wr_blocked);
  a_r2_rom_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs && !wr_n) |-> mem_we_n);
endmodule

// File: tb/bank_map_ctrl_tb.sv
`timescale 1ns/1ps
module bank_map_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  wdata = '0;
  logic        rom_cs, shared_cs, prog_cs, scratch_cs, gen_cs;
  logic [5:0]  sup_cs;
  logic [14:0] ext_addr;
  logic [1:0]  rom_page;
  logic        mem_we_n, mem_oe_n, ff_fill, wr_blocked, viol;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_bank = 0, m_page = 1;
  bit m_locked = 1, m_viol = 0;

  always #4 clk = ~clk;

  bank_map_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rom_cs(rom_cs), .shared_cs(shared_cs),
    .sup_cs(sup_cs), .prog_cs(prog_cs), .scratch_cs(scratch_cs), .gen_cs(gen_cs),
    .ext_addr(ext_addr), .rom_page(rom_page), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .ff_fill(ff_fill), .wr_blocked(wr_blocked), .viol(viol)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_sel(input logic [15:0] a);
    logic [10:0] s = '0;
    if (a < 16'hA000)      s[10] = 1'b1;
    else if (a < 16'hC000) s[9] = 1'b1;
    else if (a < 16'hF000) s[3 + ((a - 16'hC000) >> 11)] = 1'b1;
    else if (a < 16'hF800) s[2] = 1'b1;
    else if (a < 16'hF900) s[1] = 1'b1;
    else                   s[0] = 1'b1;
    return s;
  endfunction

  function automatic bit guarded(input logic [15:0] a);
    return (a >= 16'hC000 && a < 16'hC800) || (a >= 16'hF000 && a < 16'hF800);
  endfunction

  function automatic string reg_tag(input logic [15:0] a);
    if (a < 16'hA000) return "R2";
    if (a < 16'hC000) return "R3";
    if (a < 16'hF000) return "R4";
    return "R5";
  endfunction

  // one memory cycle: strobe held for one clock, then released for one clock
  task automatic mem_acc(input logic [15:0] a, input bit w, input logic [7:0] d, input string tag);
    bit g, bw, br, st_lock, st_magic;
    logic [14:0] exp_ext;
    @(negedge clk);
    addr = a; mreq_n = 1'b0; iorq_n = 1'b1; rd_n = w; wr_n = !w; wdata = d;
    #1;
    g  = guarded(a);
    bw = w && (a < 16'hA000 || (g && m_locked));
    br = !w && g && m_locked;
    exp_ext = (a >= 16'hF000) ? 15'((m_bank << 12) | (a & 16'h0FFF)) : 15'd0;
    chk(tag, {rom_cs, shared_cs, sup_cs, prog_cs, scratch_cs, gen_cs}, exp_sel(a));
    chk(tag, ext_addr, exp_ext);
    chk(tag, {mem_we_n, mem_oe_n, ff_fill, wr_blocked}, {!w || bw, w || br, br, bw});
    st_lock  = g && !m_locked;
    st_magic = !w && a == 16'h1FFF;
    if (g && m_locked) m_viol = 1;
    @(negedge clk);
    mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    #1;
    chk("R10", viol, m_viol);
    if (st_lock) m_locked = 1;
    else if (st_magic) m_locked = 0;
  endtask

  task automatic io_write(input logic [7:0] p, input logic [7:0] v, input string tag);
    @(negedge clk);
    addr = {8'h00, p}; mreq_n = 1'b1; iorq_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0; wdata = v;
    #1;
    chk("R11", {rom_cs, shared_cs, sup_cs, prog_cs, scratch_cs, gen_cs, mem_we_n, mem_oe_n},
        13'b0_0000_0000_0011);
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
    #1;
    if (p == 8'hDC && v < 5) m_bank = v;
    if (p == 8'hDD && v >= 1 && v <= 3) m_page = v;
    chk(tag, rom_page, m_page);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1", rom_page, 2'd1);
    chk("R1", viol, 1'b0);
    mem_acc(16'hF900, 0, 8'h00, "R1");        // bank 0 at reset
    mem_acc(16'hF000, 0, 8'h00, "R1");        // locked at reset, sets viol
    // boundaries
    foreach (ra_list[i]) mem_acc(ra_list[i], 0, 8'h00, reg_tag(ra_list[i]));
    // R2 writes to program store ignored
    mem_acc(16'h0100, 1, 8'h5A, "R2");
    mem_acc(16'h9FFF, 1, 8'h5A, "R2");
    // R6 bank register
    io_write(8'hDC, 8'd3, "R6");
    mem_acc(16'hF900, 0, 8'h00, "R6");
    io_write(8'hDC, 8'd7, "R6");
    io_write(8'hDC, 8'd5, "R6");
    mem_acc(16'hFFFF, 0, 8'h00, "R6");
    io_write(8'hDC, 8'd4, "R6");
    mem_acc(16'hF800, 1, 8'h11, "R6");
    // R7 page register
    io_write(8'hDD, 8'd2, "R7");
    io_write(8'hDD, 8'd0, "R7");
    io_write(8'hDD, 8'd4, "R7");
    io_write(8'hDD, 8'd3, "R7");
    // R8 and R9 one-shot unlock
    mem_acc(16'h1FFF, 0, 8'h00, "R8");
    mem_acc(16'hC000, 1, 8'hA5, "R8");
    mem_acc(16'hC7FF, 1, 8'hA5, "R9");
    mem_acc(16'h1FFF, 0, 8'h00, "R8");
    mem_acc(16'hF123, 0, 8'h00, "R9");
    mem_acc(16'hF123, 0, 8'h00, "R9");
    mem_acc(16'h1FFF, 1, 8'h00, "R8");        // write does not unlock
    mem_acc(16'hF000, 1, 8'h00, "R10");
    mem_acc(16'hC400, 0, 8'h00, "R10");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: ra = 16'($urandom);
        1: ra = 16'hC000 + 16'($urandom_range(0, 16'h2FFF));
        2: ra = 16'hF000 + 16'($urandom_range(0, 16'h0FFF));
        default: ra = 16'h1FFF;
      endcase
      if (op < 7) mem_acc(ra, op[0], 8'($urandom), reg_tag(ra));
      else if (op == 7) io_write(8'hDC, 8'($urandom_range(0, 7)), "R6");
      else if (op == 8) io_write(8'hDD, 8'($urandom_range(0, 4)), "R7");
      else io_write(8'($urandom), 8'($urandom), "R11");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  logic [15:0] ra_list [13] = '{16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000, 16'hC7FF,
                                16'hC800, 16'hE800, 16'hEFFF, 16'hF7FF, 16'hF800,
                                16'hF8FF, 16'hF900, 16'h0000};
endmodule